// File: doc/BRIEF.md
# UART Channel Control Front End

This block is the register-side controller of a single serial channel inside a multi-channel UART. It watches a byte-wide write bus, claims the eight-address window that belongs to its channel, and turns writes into control state. The state covers the receiver and transmitter enable levels, one-cycle reset pulses for the receive and transmit datapaths, an error-clear pulse, and the line-break drive. It also holds three mode registers, which are reached one after another through an advancing pointer. From these it drives the character format: data bits, parity and stop length. It also drives the extended-FIFO options.

The serial shifters, the FIFOs and the baud generator sit outside the block. They report their condition through status inputs. The block gathers those inputs, together with its own sticky error flags, into a status byte that can be read back over the bus. The mode pointer is a three-state machine. Its states are PTR_MR0, PTR_MR1 and PTR_MR2. Its transitions are `go_mr1`, taken on the point-to-MR1 command; `go_mr0`, taken on the point-to-MR0 command; and `advance`, taken on each mode write, which moves PTR_MR0 to PTR_MR1 and PTR_MR1 to PTR_MR2. There is also `hold`: a mode write in PTR_MR2 stays in PTR_MR2, and the machine also stays where it is when it has no stimulus.

Top module: `uart_chan_ctrl`

## Requirements
- R1: The block acts only on bus writes whose upper address bits (`bus_addr[ADDR_W-1:3]`) equal `CHAN_IDX`. Within that window, offset 0 is the mode register, offset 1 reads status and offset 2 is the command register. Writes to offsets 1 and 3 change nothing. `bus_rdata` shows the status byte only when the address is this channel's offset 1, and is zero for any other address.
- R2: In a command byte, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If both bits of a pair are 1, the disable takes effect. A pair with neither bit set leaves its enable unchanged.
- R3: Bits 7:4 of the same command byte carry a command code, and that code takes effect in the same write as the enable bits. A receiver-reset (code 2) or transmitter-reset (code 3) code overrides an enable bit of its own pair.
- R4: The mode pointer starts at MR1. Code 1 points it to MR1 and code 0xB points it to MR0. Each write to offset 0 loads the register the pointer selects and then advances the pointer, from MR0 to MR1 and from MR1 to MR2. The pointer stays on MR2 for every later mode write.
- R5: MR1 bits 1:0 set `word_len`, where 0 to 3 mean 5 to 8 data bits. If MR1 bit 4 is 1, parity is off. If it is 0, parity is on, and MR1 bit 2 selects odd (1) or even (0) parity.
- R6: MR2 bit 3 sets `stop_two`, so a low nibble of 0x7 gives one stop bit and 0xF gives two. In MR0, bit 3 drives `fifo_ext_en`, bit 4 drives `tx_half_level` and bits 2:0 drive `baud_ext_sel`.
- R7: Code 2 disables the receiver and raises `rx_reset_pulse` for the one cycle after the write. It clears the four sticky error flags. It also forces status bits 0 and 1 to zero until a later command enables the receiver.
- R8: Code 3 disables the transmitter, raises `tx_reset_pulse` for the one cycle after the write, and ends any break. While the transmitter is disabled, status bit 3 (empty) reads 1 and status bit 2 (ready) reads 0. While it is enabled, those two bits follow `tx_empty_in` and `tx_ready_in`.
- R9: The status bits are: bit 0 receive ready, bit 1 receive full, bit 2 transmit ready, bit 3 transmit empty, bit 4 overrun, bit 5 parity error, bit 6 framing error and bit 7 received break. Bits 7:4 are sticky and are set in any cycle where the matching input is high. Code 4 clears them and raises `err_clear_pulse` for one cycle. An input that is high in the clearing cycle sets its flag again.
- R10: `break_change` is set whenever `break_rx_in` differs from its value in the previous cycle, and it stays set until code 5. A change in the cycle of the clear sets it again.
- R11: Code 6 asserts `break_out`. It stays asserted until code 7 or code 3.
- R12: After reset, both the receiver and the transmitter are disabled. The pointer is on MR1 and all mode registers are zero (5 data bits, even parity, one stop bit). `break_out` is low, all flags are clear and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address; the upper bits select the channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status byte when this channel's offset 1 is addressed, else zero |
| rx_ready_in | input | 1 | Receive FIFO holds data |
| rx_full_in | input | 1 | Receive FIFO full |
| tx_ready_in | input | 1 | Transmit FIFO can accept a byte |
| tx_empty_in | input | 1 | Transmitter fully drained |
| overrun_in | input | 1 | Overrun event |
| parity_err_in | input | 1 | Parity error event |
| frame_err_in | input | 1 | Framing error event |
| break_rx_in | input | 1 | Line break currently detected on the receive line |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| rx_reset_pulse | output | 1 | One-cycle reset for the receive path |
| tx_reset_pulse | output | 1 | One-cycle reset for the transmit path |
| err_clear_pulse | output | 1 | One-cycle error-status clear |
| break_out | output | 1 | Force a break onto the transmit line |
| break_change | output | 1 | Sticky change-of-break indicator |
| word_len | output | 2 | Data bits minus five |
| parity_en | output | 1 | Parity generation and check on |
| parity_odd | output | 1 | Odd parity selected |
| stop_two | output | 1 | Two stop bits |
| fifo_ext_en | output | 1 | Extended FIFO enabled |
| tx_half_level | output | 1 | Transmit ready at half-full level |
| baud_ext_sel | output | 3 | Extended baud table select |

## Verification
Some rules are checked on every cycle by assertions. A set disable bit always leaves its enable off on the next cycle. The break drive holds until one of its two ending commands arrives. A reset pulse is always preceded by its command. The pointer never leaves MR2 without a pointer command. A clear with no new event leaves the error flags empty. Other behaviour only the scenarios can show. These include the decoding of each format field and of the MR0 fields. They also include address decoding across other channels' windows, a clear that collides with a fresh error event, and the mask on receive status after a receiver reset until it is enabled again.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    // Mode-register pointer states
    typedef enum logic [1:0] {
        PTR_MR0 = 2'd0,
        PTR_MR1 = 2'd1,
        PTR_MR2 = 2'd2
    } mode_ptr_e;

    // Command codes carried in bits 7:4 of the command byte
    localparam logic [3:0] CMD_PTR_MR1 = 4'h1;
    localparam logic [3:0] CMD_RX_RST  = 4'h2;
    localparam logic [3:0] CMD_TX_RST  = 4'h3;
    localparam logic [3:0] CMD_ERR_CLR = 4'h4;
    localparam logic [3:0] CMD_BKC_CLR = 4'h5;
    localparam logic [3:0] CMD_BRK_ON  = 4'h6;
    localparam logic [3:0] CMD_BRK_OFF = 4'h7;
    localparam logic [3:0] CMD_PTR_MR0 = 4'hB;

    // Offsets inside the eight-address channel window
    localparam logic [2:0] OFS_MODE = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CMD  = 3'd2;

    // Sticky error flags, packed in status-bit order (bit 7 down to bit 4)
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;

endpackage

// File: rtl/ucc_cmd_ctrl.sv
module ucc_cmd_ctrl
    import ucc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic       rx_en,
    output logic       tx_en,
    output logic       rx_rst_p,
    output logic       tx_rst_p,
    output logic       err_clr_p,
    output logic       brk_out,
    output logic       rx_rst_stb,
    output logic       err_clr_stb,
    output logic       bkc_clr_stb,
    output logic       rx_on_stb,
    output logic       sel_mr1,
    output logic       sel_mr0
);

    localparam int NUM_DIR = 2; // index 0 receiver, index 1 transmitter

    logic [3:0]         code;
    logic [NUM_DIR-1:0] en_vec;

    assign code = cmd_byte[7:4];

    // One enable/disable pair per direction; the reset code of the
    // direction and the disable bit both beat the enable bit.
    genvar g;
    for (g = 0; g < NUM_DIR; g++) begin : g_pair
        localparam logic [3:0] RST_CODE = (g == 0) ? CMD_RX_RST : CMD_TX_RST;
        logic en_r;
        logic on_b;
        logic off_b;

        assign on_b  = cmd_byte[2*g];
        assign off_b = cmd_byte[2*g+1] || (code == RST_CODE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r <= 1'b0;
            end else if (cmd_wr) begin
                if (off_b)
                    en_r <= 1'b0;
                else if (on_b)
                    en_r <= 1'b1;
            end
        end

        assign en_vec[g] = en_r;
    end

    assign rx_en = en_vec[0];
    assign tx_en = en_vec[1];

    // Strobes used by neighbouring logic on the same edge
    assign rx_rst_stb  = cmd_wr && (code == CMD_RX_RST);
    assign err_clr_stb = cmd_wr && (code == CMD_ERR_CLR);
    assign bkc_clr_stb = cmd_wr && (code == CMD_BKC_CLR);
    assign rx_on_stb   = cmd_wr && cmd_byte[0] && !cmd_byte[1] && (code != CMD_RX_RST);
    assign sel_mr1     = cmd_wr && (code == CMD_PTR_MR1);
    assign sel_mr0     = cmd_wr && (code == CMD_PTR_MR0);

    // Registered one-cycle pulses toward the datapaths
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_rst_p  <= 1'b0;
            tx_rst_p  <= 1'b0;
            err_clr_p <= 1'b0;
        end else begin
            rx_rst_p  <= rx_rst_stb;
            tx_rst_p  <= cmd_wr && (code == CMD_TX_RST);
            err_clr_p <= err_clr_stb;
        end
    end

    // Break drive: set by start, cleared by stop or transmitter reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_out <= 1'b0;
        end else if (cmd_wr) begin
            if (code == CMD_BRK_ON)
                brk_out <= 1'b1;
            else if ((code == CMD_BRK_OFF) || (code == CMD_TX_RST))
                brk_out <= 1'b0;
        end
    end

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[1] |=> !rx_en); // R2

    AST_BREAK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out && !(cmd_wr && ((cmd_byte[7:4] == CMD_BRK_OFF) || (cmd_byte[7:4] == CMD_TX_RST)))
        |=> brk_out); // R11

    AST_RX_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_p |-> $past(cmd_wr && (cmd_byte[7:4] == CMD_RX_RST))); // R7

    AST_TX_RESET_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (cmd_byte[7:4] == CMD_TX_RST) |=> !tx_en && !brk_out && tx_rst_p); // R8

endmodule

// File: rtl/ucc_mode_regs.sv
module ucc_mode_regs
    import ucc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [4:0] mode_byte,
    input  logic       sel_mr1,
    input  logic       sel_mr0,
    output logic [1:0] word_len,
    output logic       parity_en,
    output logic       parity_odd,
    output logic       stop_two,
    output logic       fifo_ext_en,
    output logic       tx_half_level,
    output logic [2:0] baud_ext_sel
);

    mode_ptr_e ptr_q;
    mode_ptr_e ptr_d;

    logic [4:0] mr0_q;   // bits 4:0 of MR0
    logic [3:0] mr1_q;   // MR1 bits {4,2,1,0}
    logic       mr2_q;   // MR2 bit 3

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= PTR_MR1;
        else
            ptr_q <= ptr_d;
    end

    // Transitions: go_mr0, go_mr1, advance, hold
    always_comb begin
        ptr_d = ptr_q;
        if (sel_mr0) begin
            ptr_d = PTR_MR0;
        end else if (sel_mr1) begin
            ptr_d = PTR_MR1;
        end else if (mode_wr) begin
            unique case (ptr_q)
                PTR_MR0: ptr_d = PTR_MR1;
                PTR_MR1: ptr_d = PTR_MR2;
                PTR_MR2: ptr_d = PTR_MR2;
                default: ptr_d = PTR_MR1;
            endcase
        end
    end

    // Register loads selected by the current pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr0_q <= '0;
            mr1_q <= '0;
            mr2_q <= 1'b0;
        end else if (mode_wr) begin
            unique case (ptr_q)
                PTR_MR0: mr0_q <= mode_byte;
                PTR_MR1: mr1_q <= {mode_byte[4], mode_byte[2:0]};
                PTR_MR2: mr2_q <= mode_byte[3];
                default: mr1_q <= mr1_q;
            endcase
        end
    end

    // Output decode
    always_comb begin
        word_len      = mr1_q[1:0];
        parity_en     = !mr1_q[3];
        parity_odd    = !mr1_q[3] && mr1_q[2];
        stop_two      = mr2_q;
        fifo_ext_en   = mr0_q[3];
        tx_half_level = mr0_q[4];
        baud_ext_sel  = mr0_q[2:0];
    end

    AST_PTR_STAYS_MR2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_MR2) && !sel_mr0 && !sel_mr1 |=> (ptr_q == PTR_MR2)); // R4

    AST_PTR_TO_MR1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mr1 && !sel_mr0 |=> (ptr_q == PTR_MR1)); // R4

endmodule

// File: rtl/ucc_status.sv
module ucc_status
    import ucc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_ready_in,
    input  logic       rx_full_in,
    input  logic       tx_ready_in,
    input  logic       tx_empty_in,
    input  err_flags_t err_in,
    input  logic       break_rx_in,
    input  logic       tx_en,
    input  logic       rx_rst_stb,
    input  logic       err_clr_stb,
    input  logic       rx_on_stb,
    input  logic       bkc_clr_stb,
    output logic [7:0] status,
    output logic       brk_change
);

    err_flags_t err_q;
    logic       flush_q;
    logic       brk_prev_q;
    logic       err_clr_any;

    assign err_clr_any = rx_rst_stb || err_clr_stb;

    // Sticky error flags; a new event in the clearing cycle survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= '0;
        else if (err_clr_any)
            err_q <= err_in;
        else
            err_q <= err_q | err_in;
    end

    // Receive status mask after a receiver reset, lifted by a receiver enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flush_q <= 1'b1;
        else if (rx_rst_stb)
            flush_q <= 1'b1;
        else if (rx_on_stb)
            flush_q <= 1'b0;
    end

    // Change-of-break detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_prev_q <= 1'b0;
            brk_change <= 1'b0;
        end else begin
            brk_prev_q <= break_rx_in;
            if (bkc_clr_stb)
                brk_change <= (break_rx_in != brk_prev_q);
            else if (break_rx_in != brk_prev_q)
                brk_change <= 1'b1;
        end
    end

    always_comb begin
        status[3:0] = {tx_empty_in || !tx_en,
                       tx_ready_in && tx_en,
                       rx_full_in && !flush_q,
                       rx_ready_in && !flush_q};
        status[7:4] = err_q;
    end

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_stb && (err_in == '0) |=> (status[7:4] == 4'h0)); // R9

    AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_stb |=> (status[1:0] == 2'b00)); // R7

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import ucc_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int CHAN_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_ready_in,
    input  logic              rx_full_in,
    input  logic              tx_ready_in,
    input  logic              tx_empty_in,
    input  logic              overrun_in,
    input  logic              parity_err_in,
    input  logic              frame_err_in,
    input  logic              break_rx_in,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              rx_reset_pulse,
    output logic              tx_reset_pulse,
    output logic              err_clear_pulse,
    output logic              break_out,
    output logic              break_change,
    output logic [1:0]        word_len,
    output logic              parity_en,
    output logic              parity_odd,
    output logic              stop_two,
    output logic              fifo_ext_en,
    output logic              tx_half_level,
    output logic [2:0]        baud_ext_sel
);

    localparam int CH_W = ADDR_W - 3;
    localparam logic [CH_W-1:0] MY_CHAN = CH_W'(CHAN_IDX);

    logic       chan_hit;
    logic [2:0] offset;
    logic       cmd_wr;
    logic       mode_wr;
    logic [7:0] status;
    err_flags_t err_in;

    logic rx_rst_stb;
    logic err_clr_stb;
    logic bkc_clr_stb;
    logic rx_on_stb;
    logic sel_mr1;
    logic sel_mr0;

    assign chan_hit = (bus_addr[ADDR_W-1:3] == MY_CHAN);
    assign offset   = bus_addr[2:0];
    assign cmd_wr   = bus_wr && chan_hit && (offset == OFS_CMD);
    assign mode_wr  = bus_wr && chan_hit && (offset == OFS_MODE);
    assign err_in   = '{brk: break_rx_in, frm: frame_err_in, par: parity_err_in, ovr: overrun_in};

    assign bus_rdata = (chan_hit && (offset == OFS_STAT)) ? status : 8'h00;

    ucc_cmd_ctrl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_byte    (bus_wdata),
        .rx_en       (rx_enable),
        .tx_en       (tx_enable),
        .rx_rst_p    (rx_reset_pulse),
        .tx_rst_p    (tx_reset_pulse),
        .err_clr_p   (err_clear_pulse),
        .brk_out     (break_out),
        .rx_rst_stb  (rx_rst_stb),
        .err_clr_stb (err_clr_stb),
        .bkc_clr_stb (bkc_clr_stb),
        .rx_on_stb   (rx_on_stb),
        .sel_mr1     (sel_mr1),
        .sel_mr0     (sel_mr0)
    );

    ucc_mode_regs u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_wr       (mode_wr),
        .mode_byte     (bus_wdata[4:0]),
        .sel_mr1       (sel_mr1),
        .sel_mr0       (sel_mr0),
        .word_len      (word_len),
        .parity_en     (parity_en),
        .parity_odd    (parity_odd),
        .stop_two      (stop_two),
        .fifo_ext_en   (fifo_ext_en),
        .tx_half_level (tx_half_level),
        .baud_ext_sel  (baud_ext_sel)
    );

    ucc_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_ready_in (rx_ready_in),
        .rx_full_in  (rx_full_in),
        .tx_ready_in (tx_ready_in),
        .tx_empty_in (tx_empty_in),
        .err_in      (err_in),
        .break_rx_in (break_rx_in),
        .tx_en       (tx_enable),
        .rx_rst_stb  (rx_rst_stb),
        .err_clr_stb (err_clr_stb),
        .rx_on_stb   (rx_on_stb),
        .bkc_clr_stb (bkc_clr_stb),
        .status      (status),
        .brk_change  (break_change)
    );

    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !chan_hit && !rx_enable |=> !rx_enable); // R1

endmodule

// File: tb/uart_chan_ctrl_test.sv
module uart_chan_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = 7'h09;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic rx_ready_in = 0, rx_full_in = 0, tx_ready_in = 0, tx_empty_in = 0;
    logic overrun_in = 0, parity_err_in = 0, frame_err_in = 0, break_rx_in = 0;
    logic rx_enable, tx_enable, rx_reset_pulse, tx_reset_pulse, err_clear_pulse;
    logic break_out, break_change, parity_en, parity_odd, stop_two;
    logic fifo_ext_en, tx_half_level;
    logic [1:0] word_len;
    logic [2:0] baud_ext_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_chan_ctrl #(.ADDR_W(AW), .CHAN_IDX(1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_ready_in(rx_ready_in), .rx_full_in(rx_full_in),
        .tx_ready_in(tx_ready_in), .tx_empty_in(tx_empty_in),
        .overrun_in(overrun_in), .parity_err_in(parity_err_in),
        .frame_err_in(frame_err_in), .break_rx_in(break_rx_in),
        .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_reset_pulse(rx_reset_pulse), .tx_reset_pulse(tx_reset_pulse),
        .err_clear_pulse(err_clear_pulse), .break_out(break_out),
        .break_change(break_change), .word_len(word_len),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop_two(stop_two),
        .fifo_ext_en(fifo_ext_en), .tx_half_level(tx_half_level),
        .baud_ext_sel(baud_ext_sel)
    );

    // ---------------- behavioural reference model ----------------
    bit       m_rx, m_tx, m_flush, m_bkc, m_bprev, m_brk, m_rxp, m_txp, m_ecp;
    bit [3:0] m_err;
    int       m_ptr;
    bit [7:0] m_mr0, m_mr1, m_mr2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_flush = 1; m_bkc = 0; m_bprev = 0; m_brk = 0;
            m_rxp = 0; m_txp = 0; m_ecp = 0; m_err = 0; m_ptr = 1;
            m_mr0 = 0; m_mr1 = 0; m_mr2 = 0;
        end else begin
            bit       hit, cw, mw, chg;
            int       c;
            bit [3:0] ev;
            hit = (bus_addr[6:3] == 4'd1);
            cw  = bus_wr && hit && (bus_addr[2:0] == 3'd2);
            mw  = bus_wr && hit && (bus_addr[2:0] == 3'd0);
            c   = bus_wdata[7:4];
            ev  = {break_rx_in, frame_err_in, parity_err_in, overrun_in};
            chg = (break_rx_in != m_bprev);
            m_rxp = cw && c == 2;
            m_txp = cw && c == 3;
            m_ecp = cw && c == 4;
            if (cw && (c == 2 || c == 4)) m_err = ev; else m_err = m_err | ev;
            if (cw && c == 5) m_bkc = chg; else m_bkc = m_bkc | chg;
            m_bprev = break_rx_in;
            if (cw) begin
                if (c == 2 || bus_wdata[1]) m_rx = 0; else if (bus_wdata[0]) m_rx = 1;
                if (c == 2) m_flush = 1; else if (bus_wdata[0] && !bus_wdata[1]) m_flush = 0;
                if (c == 3 || bus_wdata[3]) m_tx = 0; else if (bus_wdata[2]) m_tx = 1;
                if (c == 6) m_brk = 1; else if (c == 7 || c == 3) m_brk = 0;
                if (c == 1) m_ptr = 1; else if (c == 11) m_ptr = 0;
            end
            if (mw) begin
                case (m_ptr)
                    0: begin m_mr0 = bus_wdata; m_ptr = 1; end
                    1: begin m_mr1 = bus_wdata; m_ptr = 2; end
                    default: m_mr2 = bus_wdata;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [7:0] st;
            st = {m_err, tx_empty_in | ~m_tx, tx_ready_in & m_tx,
                  rx_full_in & ~m_flush, rx_ready_in & ~m_flush};
            chk("R2/R3 enables", {rx_enable, tx_enable}, {m_rx, m_tx});
            chk("R7 rx reset pulse", rx_reset_pulse, m_rxp);
            chk("R8 tx reset pulse", tx_reset_pulse, m_txp);
            chk("R9 error clear pulse", err_clear_pulse, m_ecp);
            chk("R11 break drive", break_out, m_brk);
            chk("R10 break change", break_change, m_bkc);
            chk("R4/R5 format", {word_len, parity_en, parity_odd},
                {m_mr1[1:0], ~m_mr1[4], ~m_mr1[4] & m_mr1[2]});
            chk("R6 stop and MR0 fields", {stop_two, fifo_ext_en, tx_half_level, baud_ext_sel},
                {m_mr2[3], m_mr0[3], m_mr0[4], m_mr0[2:0]});
            chk("R1/R9 read data", bus_rdata,
                (bus_addr[6:3] == 4'd1 && bus_addr[2:0] == 3'd1) ? st : 8'h00);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_addr = 7'h09;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cmp_on = 1;
        settle();
        // R12 reset state
        chk("R12 reset enables/break", {rx_enable, tx_enable, break_out, break_change}, 4'b0000);
        chk("R12 reset format", {word_len, parity_en, parity_odd, stop_two}, 5'b00100);
        chk("R12 reset status", bus_rdata, 8'h08);

        // R1: command written to another channel's window is ignored
        wr(7'h02, 8'h05); settle();
        chk("R1 foreign channel ignored", {rx_enable, tx_enable}, 2'b00);
        wr(7'h0B, 8'h05); settle();
        chk("R1 data offset write ignored", {rx_enable, tx_enable}, 2'b00);
        wr(7'h0A, 8'h05); settle();
        chk("R2 both enabled", {rx_enable, tx_enable}, 2'b11);

        // R2: disable beats enable in one pair
        wr(7'h0A, 8'h03); settle();
        chk("R2 disable wins", {rx_enable, tx_enable}, 2'b01);

        // R4/R5/R6: pointer sequence starting at MR1
        wr(7'h08, 8'h13); wr(7'h08, 8'h0F); settle();
        chk("R5 eight bits no parity", {word_len, parity_en}, 3'b110);
        chk("R6 two stop bits", stop_two, 1'b1);
        wr(7'h08, 8'h07); settle();
        chk("R4 pointer holds on MR2", {stop_two, word_len}, 3'b011);
        wr(7'h0A, 8'hB0); wr(7'h08, 8'h1D); settle();
        chk("R6 MR0 fields", {fifo_ext_en, tx_half_level, baud_ext_sel}, 5'b11101);
        wr(7'h08, 8'h06); settle();
        chk("R4 MR0 advances to MR1", {word_len, parity_en, parity_odd}, 4'b1011);

        // R3/R11/R8: break start held, then transmitter reset ends it
        wr(7'h0A, 8'h64); repeat (3) settle();
        chk("R11 break held", {break_out, tx_enable}, 2'b11);
        @(posedge clk); #1; tx_empty_in = 0;
        wr(7'h0A, 8'h34); settle();
        chk("R8 tx reset overrides enable", {break_out, tx_enable}, 2'b00);
        chk("R8 empty while disabled", bus_rdata[3:2], 2'b10);

        // R9: sticky error, clear
        @(posedge clk); #1; parity_err_in = 1;
        @(posedge clk); #1; parity_err_in = 0;
        settle();
        chk("R9 parity flag sticky", bus_rdata[5], 1'b1);
        wr(7'h0A, 8'h40); settle();
        chk("R9 flags cleared", bus_rdata[7:4], 4'h0);

        // R7: receiver reset masks receive status until re-enabled
        @(posedge clk); #1; rx_ready_in = 1;
        wr(7'h0A, 8'h01); settle();
        chk("R7 rx ready visible", bus_rdata[0], 1'b1);
        wr(7'h0A, 8'h21); settle();
        chk("R7 rx reset masks and disables", {bus_rdata[0], rx_enable}, 2'b00);
        wr(7'h0A, 8'h01); settle();
        chk("R7 re-enable unmasks", bus_rdata[0], 1'b1);

        // R10: break change set and cleared
        @(posedge clk); #1; break_rx_in = 1;
        settle();
        settle();
        chk("R10 change seen", break_change, 1'b1);
        wr(7'h0A, 8'h50); settle();
        chk("R10 change cleared", break_change, 1'b0);
        @(posedge clk); #1; break_rx_in = 0; rx_ready_in = 0;

        // Random phase, compared on every clock by the model
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            begin
                int k;
                bit [3:0] codes [10];
                codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'h9};
                k = $urandom_range(0, 9);
                bus_wr = ($urandom_range(0, 2) != 0);
                case ($urandom_range(0, 6))
                    0: bus_addr = 7'h08;
                    1, 2: bus_addr = 7'h0A;
                    3: bus_addr = 7'h09;
                    4: bus_addr = 7'h0B;
                    5: bus_addr = 7'h12;
                    default: bus_addr = 7'h00;
                endcase
                bus_wdata = {codes[k], 4'($urandom)};
                if (bus_addr == 7'h08) bus_wdata = 8'($urandom);
            end
            rx_ready_in   = $urandom_range(0, 1);
            rx_full_in    = ($urandom_range(0, 3) == 0);
            tx_ready_in   = $urandom_range(0, 1);
            tx_empty_in   = $urandom_range(0, 1);
            overrun_in    = ($urandom_range(0, 15) == 0);
            parity_err_in = ($urandom_range(0, 15) == 0);
            frame_err_in  = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 7) == 0) break_rx_in = ~break_rx_in;
        end
        @(posedge clk); #1; bus_wr = 0;
        settle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule